// File: doc/BRIEF.md
# Buffered Four-Channel Motor PWM Timer

This block generates four pulse-width-modulated outputs for driving a motor bridge. A single 10-bit counter, shared by all channels, runs from zero up to one less than a programmable period value and then starts again at zero. Each channel compares the shared count against its own duty value, so all four waveforms are edge-aligned and have the same period.

Software never writes a duty value straight into a live channel. Each channel has a staging word that holds a new duty value and an output-enable bit. At the end of every period, all four staging words are copied into the live duty registers in one clock cycle. A duty change therefore starts on a period boundary and cannot cut a pulse short or stretch it. The enable bit moves together with its duty value. While the committed enable bit of a channel is clear, that pin rests at its inactive level. A global polarity bit inverts all four outputs.

The register port is a plain write strobe with an address, plus a read-data output that is registered one cycle after the address. A count-enable input gates the counter.

Top module: `motor_pwm_timer`

## Requirements
- R1: While `cnt_en` is high, the counter steps by one each clock. In the cycle where the count equals N−1 (N being the period value), the next count is 0. With N = 0 the counter runs through all 1024 values. While `cnt_en` is low, the counter holds its value and no commit takes place.
- R2: The period register resets to 0x3FF. A write to it takes effect on the next clock. If the counter is already above the new value, it runs on to 1023 and wraps to 0.
- R3: All four staging words are copied into their live duty registers in the same clock, and only on a counter wrap (R1). At any other time the live duty registers keep their values. The live duty registers reset to duty 0 with the enable bit clear.
- R4: With normal polarity, the output of an enabled channel with 0 < M < N is 1 while the count is below M and 0 otherwise. Each pin is registered, so it shows the comparison for the count of the previous cycle.
- R5: An enabled channel with duty M = 0 stays at its inactive level for the whole period.
- R6: An enabled channel with duty M ≥ N (N ≠ 0) stays at its active level for the whole period.
- R7: A staging word holds the duty value in bits 9..0 and the enable bit in bit 12. Bits 15..13, 11 and 10 always read as 1 and ignore writes. The word resets to 0xEC00.
- R8: While the committed enable bit of a channel is 0, that pin is driven to the inactive level, whatever the count and the duty value.
- R9: Bit 0 of the control register (address 0) sets the polarity. When it is 1, every output is inverted: active becomes 0 and inactive becomes 1. It resets to 0.
- R10: A staging-word write in the same clock as a counter wrap is committed at that wrap.
- R11: Register map. Address 0 is the control register. Address 1 is the period register (bits 9..0). Address 2 reads the counter. Addresses 4 to 7 hold the staging words of channels 0 to 3. Addresses 8 to 11 read the live duty registers, in the same format as R7. `rdata` shows the register selected by `addr` one clock after it is presented. Output bit i belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| pwm_out | output | 4 | PWM pins, bit i is channel i |

## Verification
A software write to a staging word can land in the same clock as the period wrap that commits it. The bench provokes this by waiting until its model shows the count at N−1 and then issuing the write in exactly that cycle. The live duty register is then read back and must already hold the newly written value. A write issued a few counts before the wrap is also checked: it must stay invisible in the live register until the wrap, so deferral and same-cycle capture are told apart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int REG_W     = 16;
  localparam int FIELD_W   = 10;
  localparam int EN_BIT    = 12;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CYC  = 1;
  localparam int ADDR_CNT  = 2;
  localparam logic [REG_W-1:0] RSV_ONES = 16'hEC00;

  function automatic logic [REG_W-1:0] pack_word(input logic en,
                                                 input logic [FIELD_W-1:0] duty);
    logic [REG_W-1:0] w;
    w         = RSV_ONES | {{(REG_W-FIELD_W){1'b0}}, duty};
    w[EN_BIT] = en;
    return w;
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cyc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_inc;
  logic             at_end;

  assign cnt_inc = cnt + 1'b1;
  assign at_end  = (cnt_inc == cyc);
  assign wrap    = cnt_en & at_end;

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (cnt_en) cnt <= at_end ? '0 : cnt_inc;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R1
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt)); // R1
endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int NCH       = 4,
  parameter int ADDR_W    = 4,
  parameter int BUF_BASE  = 4,
  parameter int DUTY_BASE = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wdata,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0][REG_W-1:0] buf_words,
  input  logic [NCH-1:0][REG_W-1:0] duty_words,
  output logic                      pol,
  output logic [CNT_W-1:0]          cyc,
  output logic [REG_W-1:0]          rdata
);
  logic [REG_W-1:0] rd_next;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= 1'b0;
      cyc <= '1;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADDR_CTRL)) pol <= wdata[0];
      if (addr == ADDR_W'(ADDR_CYC))  cyc <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) rd_next = {{(REG_W-1){1'b0}}, pol};
    if (addr == ADDR_W'(ADDR_CYC))  rd_next = REG_W'(cyc);
    if (addr == ADDR_W'(ADDR_CNT))  rd_next = REG_W'(cnt);
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(BUF_BASE + i))  rd_next = buf_words[i];
      if (addr == ADDR_W'(DUTY_BASE + i)) rd_next = duty_words[i];
    end
  end

  always_ff @(posedge clk) rdata <= rd_next;

  AST_RSV_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(addr) >= ADDR_W'(BUF_BASE)) &&
     ($past(addr) < ADDR_W'(DUTY_BASE + NCH)))
    |-> (rdata[15:13] == 3'b111 && rdata[11:10] == 2'b11)); // R7
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 4,
  parameter int MY_ADR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_duty,
  input  logic              wr_en_bit,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cyc,
  input  logic              pol,
  output logic [REG_W-1:0]  buf_word,
  output logic [REG_W-1:0]  duty_word,
  output logic              pwm
);
  logic [CNT_W-1:0] stg_duty, live_duty, nxt_duty;
  logic             stg_en, live_en, nxt_en, hit, active;

  assign hit      = wr_en & (addr == ADDR_W'(MY_ADR));
  assign nxt_duty = hit ? wr_duty   : stg_duty;
  assign nxt_en   = hit ? wr_en_bit : stg_en;
  assign active   = (cnt < live_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_duty <= '0;
      stg_en   <= 1'b0;
    end else if (hit) begin
      stg_duty <= wr_duty;
      stg_en   <= wr_en_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_duty <= '0;
      live_en   <= 1'b0;
    end else if (wrap) begin
      live_duty <= nxt_duty;
      live_en   <= nxt_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= live_en ? (active ^ pol) : pol;
  end

  assign buf_word  = pack_word(stg_en,  FIELD_W'(stg_duty));
  assign duty_word = pack_word(live_en, FIELD_W'(live_duty));

  AST_LIVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(live_duty) && $stable(live_en)); // R3
  AST_COLLIDE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (hit && wrap) |=> (live_duty == $past(wr_duty))); // R10
  AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !live_en |=> (pwm == $past(pol))); // R8
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
    (live_duty == '0) |=> (pwm == $past(pol))); // R5
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
    (live_en && cyc != '0 && live_duty >= cyc && cnt < cyc)
    |=> (pwm == !$past(pol))); // R6
endmodule

// File: rtl/motor_pwm_timer.sv
module motor_pwm_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int BUF_BASE  = 4;
  localparam int DUTY_BASE = BUF_BASE + NCH;

  logic [CNT_W-1:0]          cnt, cyc;
  logic                      wrap, pol;
  logic [NCH-1:0][REG_W-1:0] buf_words, duty_words;

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cyc(cyc), .cnt(cnt), .wrap(wrap)
  );

  pwm_regif #(
    .CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W),
    .BUF_BASE(BUF_BASE), .DUTY_BASE(DUTY_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .buf_words(buf_words), .duty_words(duty_words),
    .pol(pol), .cyc(cyc), .rdata(rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MY_ADR(BUF_BASE + g)
    ) u_ch (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wr_duty(wdata[CNT_W-1:0]), .wr_en_bit(wdata[EN_BIT]),
      .wrap(wrap), .cnt(cnt), .cyc(cyc), .pol(pol),
      .buf_word(buf_words[g]), .duty_word(duty_words[g]), .pwm(pwm_out[g])
    );
  end
endmodule

// File: tb/sim_motor_pwm_timer.sv
`timescale 1ns/1ps
module sim_motor_pwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit chk_pwm = 0;

  always #2 clk = ~clk;

  motor_pwm_timer u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // Behavioural reference built from the requirements
  int   m_cnt, m_cyc;
  bit   m_pol;
  int   m_sd[4], m_ld[4];
  bit   m_se[4], m_le[4];
  bit   m_pwm[4];
  string m_tag[4];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cyc = 1023; m_pol = 0;
      for (int i = 0; i < 4; i++) begin
        m_sd[i] = 0; m_ld[i] = 0; m_se[i] = 0; m_le[i] = 0;
        m_pwm[i] = 0; m_tag[i] = "R8";
      end
    end else begin
      bit wrapm;
      wrapm = cnt_en && (((m_cnt + 1) % 1024) == m_cyc);
      for (int i = 0; i < 4; i++) begin
        if (!m_le[i]) begin m_pwm[i] = m_pol; m_tag[i] = "R8"; end
        else begin
          m_pwm[i] = (m_cnt < m_ld[i]) ^ m_pol;
          if (m_ld[i] == 0) m_tag[i] = "R5";
          else if (m_cyc != 0 && m_ld[i] >= m_cyc) m_tag[i] = "R6";
          else m_tag[i] = m_pol ? "R9" : "R4";
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (wr_en && addr == 4'(4 + i)) begin
          m_sd[i] = wdata[9:0]; m_se[i] = wdata[12];
        end
        if (wrapm) begin m_ld[i] = m_sd[i]; m_le[i] = m_se[i]; end
      end
      if (cnt_en) m_cnt = wrapm ? 0 : (m_cnt + 1) % 1024;
      if (wr_en && addr == 4'd0) m_pol = wdata[0];
      if (wr_en && addr == 4'd1) m_cyc = wdata[9:0];
    end
  end

  function automatic logic [15:0] pack(bit en, int d);
    logic [15:0] w;
    w = 16'hEC00 | 16'(d);
    w[12] = en;
    return w;
  endfunction

  function automatic logic [15:0] m_read(logic [3:0] a);
    if (a == 0) return {15'b0, m_pol};
    if (a == 1) return 16'(m_cyc);
    if (a == 2) return 16'(m_cnt);
    if (a >= 4 && a < 8)  return pack(m_se[a-4], m_sd[a-4]);
    if (a >= 8 && a < 12) return pack(m_le[a-8], m_ld[a-8]);
    return 16'h0;
  endfunction

  // Scoreboard: driver pushes, monitor pops
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s read: got %h expected %h", t, rdata, e);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_pwm && !rst) begin
      for (int i = 0; i < 4; i++) begin
        n_chk++;
        if (pwm_out[i] !== m_pwm[i]) begin
          n_fail++;
          $display("FAIL %s pwm ch%0d: got %b expected %b", m_tag[i], i,
                   pwm_out[i], m_pwm[i]);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    addr = a; wr_en = 0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic rdm(input logic [3:0] a, input string t);
    rd(a, m_read(a), t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 0;
    chk_pwm = 1;
    // Reset state: R7 staging, R3 live, R2 period, R9 control, R1 counter
    for (int i = 0; i < 4; i++) rd(4'(4 + i), 16'hEC00, "R7");
    for (int i = 0; i < 4; i++) rd(4'(8 + i), 16'hEC00, "R3");
    rd(4'd1, 16'h03FF, "R2");
    rd(4'd0, 16'h0000, "R9");
    rd(4'd2, 16'h0000, "R1");  // counter still disabled

    // R7 reserved bits ignore writes
    wr(4'd7, 16'h0000);
    rd(4'd7, 16'hEC00, "R7");
    wr(4'd7, 16'hFFFF);
    rd(4'd7, 16'hFFFF, "R7");

    // R2: period 20; duties 0, 7, 20, 25 (R5, R4, R6, R6)
    wr(4'd1, 16'd20);
    rd(4'd1, 16'd20, "R2");
    wr(4'd4, 16'h1000);
    wr(4'd5, 16'h1007);
    wr(4'd6, 16'h1014);
    wr(4'd7, 16'h1019);
    rd(4'd9, 16'hEC00, "R3");  // not yet committed
    cnt_en = 1;
    idle(25);
    rd(4'd8,  16'hFC00, "R3");
    rd(4'd9,  16'hFC07, "R3");
    rd(4'd10, 16'hFC14, "R3");
    rd(4'd11, 16'hFC19, "R3");
    idle(60);

    // R3: staged change stays out of live register until the wrap
    wait_cnt(5);
    wr(4'd5, 16'h100C);
    rd(4'd9, 16'hFC07, "R3");
    wait_cnt(2);
    rd(4'd9, 16'hFC0C, "R3");

    // R10: write in the wrap cycle itself
    wait_cnt(19);
    wr(4'd5, 16'h1003);
    rd(4'd9, 16'hFC03, "R10");
    idle(45);

    // R9: polarity inversion
    wr(4'd0, 16'h0001);
    rd(4'd0, 16'h0001, "R9");
    idle(60);
    wr(4'd0, 16'h0000);

    // R8: disable channel 1 while polarity inverted then normal
    wr(4'd5, 16'h000C);
    idle(45);
    wr(4'd0, 16'h0001);
    idle(45);
    wr(4'd0, 16'h0000);
    rd(4'd9, 16'hEC0C, "R8");

    // R1: counter holds while disabled
    cnt_en = 0;
    idle(2);
    rdm(4'd2, "R1");
    idle(5);
    rdm(4'd2, "R1");
    rd(4'd9, 16'hEC0C, "R3");
    cnt_en = 1;

    // R1: period 0 runs the full 1024 range
    wr(4'd5, 16'h1200);
    wr(4'd1, 16'h0000);
    idle(2100);
    rdm(4'd2, "R1");

    // R2: lower the period below the running count
    wait_cnt(100);
    wr(4'd1, 16'd5);
    rdm(4'd2, "R2");
    idle(1000);
    rdm(4'd2, "R2");
    idle(40);
    rdm(4'd9, "R11");
    rdm(4'd2, "R11");

    idle(3);
    finish_run();
  end
endmodule